// File: doc/BRIEF.md
# Bulk Transmit Endpoint DMA Handshake

This block sits on the transmit side of a bulk endpoint whose FIFO is filled by a DMA engine, one byte at a time. It counts the bytes of the packet being loaded and the packets already committed for transmission. From these counts it drives a request line that asks the DMA engine for the next maximum-size packet. When automatic commit is on, the byte that completes a maximum-size packet also commits that packet. The CPU commits short packets and zero-length packets itself with a strobe.

The FIFO has room for `NUM_SLOTS` committed packets (double buffering by default). The ready flag reports that every slot is committed and waiting for the bus. A transmit-success pulse frees the oldest slot. In host mode, `RETRY_LIMIT` failed attempts in a row raise a sticky error. That error masks the request line until software clears it.

Byte loading uses a valid/ready handshake. `wr_ready` does not depend on `wr_valid`. A byte moves on every clock where both are high. The DMA engine may hold `wr_valid` high across cycles where `wr_ready` is low, and nothing is lost. `max_pkt_size` must be nonzero and is held stable while a packet is being loaded. The usual values are 512 bytes at high speed and 64 bytes at full speed.

Top module: `bulk_tx_dma_ctl`

## Requirements
- R1: After reset `pkt_count` is 0, `pkt_rdy` and `tx_err` are low, `wr_ready` is high, and no bytes are counted toward the current packet.
- R2: `dma_req` is high only when `dma_en` and `dma_mode1` are both high, `tx_err` is low, a slot is free and the current packet holds fewer than `max_pkt_size` bytes. Under those conditions it is high.
- R3: A byte is accepted on a clock where `wr_valid` and `wr_ready` are both high. `wr_ready` is high when a slot is free and the current packet holds fewer than `max_pkt_size` bytes. Without automatic commit, after `max_pkt_size` bytes both `wr_ready` and `dma_req` stay low until a commit.
- R4: With `auto_set_en` high, the accepted byte that brings the current packet to `max_pkt_size` commits it at that same edge. After that edge `pkt_count` is one higher, the byte count restarts at zero, and `wr_ready` is high again if a slot remains free.
- R5: A `cpu_set_rdy` pulse commits the current packet, whatever its length, including zero bytes (a null packet). `pkt_count` goes up by one, and a byte accepted in the same cycle belongs to that packet. The pulse is ignored when no slot is free.
- R6: `pkt_rdy` is high exactly when `pkt_count` equals `NUM_SLOTS`. While it is high, `dma_req` and `wr_ready` are low.
- R7: A `tx_ok` pulse while `pkt_count` is nonzero lowers `pkt_count` by one and zeroes the consecutive-failure tally. It is ignored when `pkt_count` is zero.
- R8: With `host_mode` high and `pkt_count` nonzero, `RETRY_LIMIT` (3) `tx_fail` pulses with no `tx_ok` between them set `tx_err`. `tx_err` stays set until an `err_clr` pulse in a cycle that sets no new error. `tx_fail` is ignored in device mode, when `pkt_count` is zero, and in a cycle that also carries `tx_ok`.
- R9: A commit and a counted `tx_ok` in the same cycle leave `pkt_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| max_pkt_size | input | MAXP_W | Maximum packet size in bytes, nonzero |
| dma_en | input | 1 | DMA enable |
| dma_mode1 | input | 1 | Request mode 1 select |
| auto_set_en | input | 1 | Commit a packet automatically when it reaches maximum size |
| host_mode | input | 1 | Count transmit failures toward the error |
| wr_valid | input | 1 | DMA byte write valid |
| wr_ready | output | 1 | Endpoint can take a byte |
| cpu_set_rdy | input | 1 | CPU pulse that commits the current packet |
| tx_ok | input | 1 | Oldest packet was sent successfully |
| tx_fail | input | 1 | Transmit attempt of the oldest packet failed |
| err_clr | input | 1 | Software clear of the error flag |
| dma_req | output | 1 | DMA request line |
| pkt_rdy | output | 1 | All slots are committed and waiting |
| tx_err | output | 1 | Retry limit reached |
| pkt_count | output | CNT_W | Committed packets waiting for the bus |

## Verification
The bench targets the edge where the last byte of a maximum-size packet arrives. A design that commits one cycle late would show `wr_ready` high with a full packet, and one without the byte-count limit would let a ninth byte in. It sends null and short packets through the CPU strobe, and tries a commit while both slots are full. A counter that wraps or ignores the full condition shows up there as a wrong `pkt_count`. It also drives `tx_ok` against an empty queue and `tx_ok` together with a commit. It then runs failure sequences broken by a success, which catch a tally that `tx_ok` does not zero: the error would appear one strike early. Last come error clear, failures in device mode, and a long random run compared cycle by cycle against a behavioural model.

// File: rtl/bulk_tx_pkg.sv
package bulk_tx_pkg;
  // Outcome of the current transmit attempt, after qualification.
  typedef enum logic [1:0] {
    TXEV_NONE = 2'd0,
    TXEV_OK   = 2'd1,
    TXEV_FAIL = 2'd2
  } tx_event_e;

  localparam int unsigned HS_MAX_PKT = 512;
  localparam int unsigned FS_MAX_PKT = 64;
endpackage

// File: rtl/pkt_fill_tracker.sv
module pkt_fill_tracker #(
  parameter int unsigned MAXP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAXP_W-1:0] max_pkt_size,
  input  logic              slot_free,
  input  logic              wr_valid,
  input  logic              cpu_set_rdy,
  input  logic              auto_set_en,
  output logic              wr_ready,
  output logic              commit
);
  logic [MAXP_W-1:0] fill_q;
  logic              room;
  logic              accept;
  logic              last_byte;

  assign room      = fill_q < max_pkt_size;
  assign wr_ready  = slot_free & room;
  assign accept    = wr_valid & wr_ready;
  assign last_byte = accept & ((fill_q + 1'b1) == max_pkt_size);
  assign commit    = slot_free & (cpu_set_rdy | (auto_set_en & last_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fill_q <= '0;
    else if (commit) fill_q <= '0;
    else if (accept) fill_q <= fill_q + 1'b1;
  end
endmodule

// File: rtl/slot_queue.sv
module slot_queue
  import bulk_tx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  tx_event_e        tx_ev,
  output logic [CNT_W-1:0] pkt_count,
  output logic             slot_free,
  output logic             pkt_rdy
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_SLOTS);

  logic [CNT_W-1:0] count_q, count_n;
  logic             rdy_q;
  logic             sent;

  assign sent = (tx_ev == TXEV_OK);

  always_comb begin
    count_n = count_q;
    if (commit && !sent)      count_n = count_q + 1'b1;
    else if (!commit && sent) count_n = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      rdy_q   <= 1'b0;
    end else begin
      count_q <= count_n;
      rdy_q   <= (count_n == FULL);
    end
  end

  assign pkt_count = count_q;
  assign slot_free = (count_q < FULL);
  assign pkt_rdy   = rdy_q;
endmodule

// File: rtl/retry_guard.sv
module retry_guard
  import bulk_tx_pkg::*;
#(
  parameter int unsigned RETRY_LIMIT = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  tx_event_e tx_ev,
  input  logic      err_clr,
  output logic      tx_err
);
  localparam int unsigned FAIL_W = (RETRY_LIMIT > 1) ? $clog2(RETRY_LIMIT) : 1;

  logic err_q;
  logic strike_out;

  generate
    if (RETRY_LIMIT <= 1) begin : g_single
      assign strike_out = (tx_ev == TXEV_FAIL);
    end else begin : g_tally
      logic [FAIL_W-1:0] fails_q;
      assign strike_out = (tx_ev == TXEV_FAIL) &&
                          (fails_q == FAIL_W'(RETRY_LIMIT - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   fails_q <= '0;
        else if (tx_ev == TXEV_OK)    fails_q <= '0;
        else if (strike_out)          fails_q <= '0;
        else if (tx_ev == TXEV_FAIL)  fails_q <= fails_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (strike_out) err_q <= 1'b1;
    else if (err_clr)    err_q <= 1'b0;
  end

  assign tx_err = err_q;
endmodule

// File: rtl/bulk_tx_dma_ctl.sv
module bulk_tx_dma_ctl
  import bulk_tx_pkg::*;
#(
  parameter int unsigned MAXP_W      = 10,
  parameter int unsigned NUM_SLOTS   = 2,
  parameter int unsigned RETRY_LIMIT = 3,
  parameter int unsigned CNT_W       = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAXP_W-1:0] max_pkt_size,
  input  logic              dma_en,
  input  logic              dma_mode1,
  input  logic              auto_set_en,
  input  logic              host_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              cpu_set_rdy,
  input  logic              tx_ok,
  input  logic              tx_fail,
  input  logic              err_clr,
  output logic              dma_req,
  output logic              pkt_rdy,
  output logic              tx_err,
  output logic [CNT_W-1:0]  pkt_count
);
  logic      slot_free;
  logic      commit;
  logic      pending;
  tx_event_e tx_ev;

  assign pending = (pkt_count != '0);

  // Success wins over a failure reported in the same cycle; both need a packet.
  always_comb begin
    tx_ev = TXEV_NONE;
    if (pending && tx_ok)                  tx_ev = TXEV_OK;
    else if (pending && tx_fail && host_mode) tx_ev = TXEV_FAIL;
  end

  pkt_fill_tracker #(.MAXP_W(MAXP_W)) u_fill (
    .clk          (clk),
    .rst_n        (rst_n),
    .max_pkt_size (max_pkt_size),
    .slot_free    (slot_free),
    .wr_valid     (wr_valid),
    .cpu_set_rdy  (cpu_set_rdy),
    .auto_set_en  (auto_set_en),
    .wr_ready     (wr_ready),
    .commit       (commit)
  );

  slot_queue #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit),
    .tx_ev     (tx_ev),
    .pkt_count (pkt_count),
    .slot_free (slot_free),
    .pkt_rdy   (pkt_rdy)
  );

  retry_guard #(.RETRY_LIMIT(RETRY_LIMIT)) u_retry (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_ev   (tx_ev),
    .err_clr (err_clr),
    .tx_err  (tx_err)
  );

  assign dma_req = dma_en & dma_mode1 & ~tx_err & wr_ready;
endmodule

// File: rtl/bulk_tx_dma_ctl_sva.sv
module bulk_tx_dma_ctl_sva #(
  parameter int unsigned MAXP_W    = 10,
  parameter int unsigned NUM_SLOTS = 2,
  parameter int unsigned CNT_W     = $clog2(NUM_SLOTS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MAXP_W-1:0] max_pkt_size,
  input logic              dma_en,
  input logic              dma_mode1,
  input logic              auto_set_en,
  input logic              host_mode,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              cpu_set_rdy,
  input logic              tx_ok,
  input logic              tx_fail,
  input logic              err_clr,
  input logic              dma_req,
  input logic              pkt_rdy,
  input logic              tx_err,
  input logic [CNT_W-1:0]  pkt_count
);
  a_r2_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_en && dma_mode1 && !tx_err && wr_ready));

  a_r6_rdy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rdy |-> (!dma_req && !wr_ready));

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_count <= CNT_W'(NUM_SLOTS));

  a_r5_cpu_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_set_rdy && !tx_ok && pkt_count < CNT_W'(NUM_SLOTS))
    |=> (pkt_count == $past(pkt_count) + 1'b1));

  a_r7_ok_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok && pkt_count != '0 && !cpu_set_rdy && !(wr_valid && wr_ready && auto_set_en))
    |=> (pkt_count == $past(pkt_count) - 1'b1));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !err_clr) |=> tx_err);

  a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !tx_fail) |=> !tx_err);

  a_r8_no_err_device: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_err && !host_mode) |=> !tx_err);
endmodule

bind bulk_tx_dma_ctl bulk_tx_dma_ctl_sva #(
  .MAXP_W(MAXP_W), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .max_pkt_size(max_pkt_size), .dma_en(dma_en),
  .dma_mode1(dma_mode1), .auto_set_en(auto_set_en), .host_mode(host_mode),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .cpu_set_rdy(cpu_set_rdy),
  .tx_ok(tx_ok), .tx_fail(tx_fail), .err_clr(err_clr), .dma_req(dma_req),
  .pkt_rdy(pkt_rdy), .tx_err(tx_err), .pkt_count(pkt_count)
);

// File: tb/bulk_tx_dma_ctl_tb.sv
module bulk_tx_dma_ctl_tb;
  localparam int MAXP_W = 10;
  localparam int SLOTS  = 2;
  localparam int LIMIT  = 3;
  localparam int CNT_W  = $clog2(SLOTS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [MAXP_W-1:0] max_pkt_size = 10'd8;
  logic dma_en = 0, dma_mode1 = 0, auto_set_en = 0, host_mode = 0;
  logic wr_valid = 0, cpu_set_rdy = 0, tx_ok = 0, tx_fail = 0, err_clr = 0;
  logic wr_ready, dma_req, pkt_rdy, tx_err;
  logic [CNT_W-1:0] pkt_count;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bulk_tx_dma_ctl #(.MAXP_W(MAXP_W), .NUM_SLOTS(SLOTS), .RETRY_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .max_pkt_size(max_pkt_size), .dma_en(dma_en),
    .dma_mode1(dma_mode1), .auto_set_en(auto_set_en), .host_mode(host_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .cpu_set_rdy(cpu_set_rdy),
    .tx_ok(tx_ok), .tx_fail(tx_fail), .err_clr(err_clr), .dma_req(dma_req),
    .pkt_rdy(pkt_rdy), .tx_err(tx_err), .pkt_count(pkt_count)
  );

  // Behavioural reference model
  int m_fill, m_cnt, m_fails;
  bit m_err;

  function automatic bit m_wr_ready();
    return (m_cnt < SLOTS) && (m_fill < int'(max_pkt_size));
  endfunction

  function automatic bit m_req();
    return dma_en && dma_mode1 && !m_err && m_wr_ready();
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fill <= 0; m_cnt <= 0; m_fails <= 0; m_err <= 0;
    end else begin : upd
      bit acc, com, ok, fl;
      acc = wr_valid && m_wr_ready();
      com = (m_cnt < SLOTS) &&
            (cpu_set_rdy || (auto_set_en && acc && (m_fill + 1 == int'(max_pkt_size))));
      ok  = tx_ok && (m_cnt > 0);
      fl  = tx_fail && !tx_ok && host_mode && (m_cnt > 0);
      m_cnt  <= m_cnt + (com ? 1 : 0) - (ok ? 1 : 0);
      m_fill <= com ? 0 : (acc ? m_fill + 1 : m_fill);
      if (ok) m_fails <= 0;
      else if (fl) begin
        if (m_fails + 1 == LIMIT) begin m_fails <= 0; m_err <= 1; end
        else m_fails <= m_fails + 1;
      end
      if (!(fl && m_fails + 1 == LIMIT) && err_clr) m_err <= 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model dma_req", int'(dma_req), int'(m_req()));
      chk("R3 model wr_ready", int'(wr_ready), int'(m_wr_ready()));
      chk("R6 model pkt_rdy", int'(pkt_rdy), int'(m_cnt == SLOTS));
      chk("R5 model pkt_count", int'(pkt_count), m_cnt);
      chk("R8 model tx_err", int'(tx_err), int'(m_err));
    end
  end

  task automatic nxt();
    @(negedge clk); #1;
  endtask

  task automatic pulse_cpu();
    cpu_set_rdy = 1; nxt(); cpu_set_rdy = 0;
  endtask
  task automatic pulse_ok();
    tx_ok = 1; nxt(); tx_ok = 0;
  endtask
  task automatic pulse_fail();
    tx_fail = 1; nxt(); tx_fail = 0;
  endtask
  task automatic load(int n);
    wr_valid = 1; repeat (n) nxt(); wr_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    nxt();
    // R1 reset state
    chk("R1 pkt_count", int'(pkt_count), 0);
    chk("R1 pkt_rdy", int'(pkt_rdy), 0);
    chk("R1 tx_err", int'(tx_err), 0);
    chk("R1 wr_ready", int'(wr_ready), 1);
    // R2 both enables needed
    dma_en = 1; dma_mode1 = 0; #1;
    chk("R2 mode0 req", int'(dma_req), 0);
    dma_en = 0; dma_mode1 = 1; #1;
    chk("R2 en0 req", int'(dma_req), 0);
    dma_en = 1; #1;
    chk("R2 both req", int'(dma_req), 1);
    // R3 full packet without auto commit, extra byte offered
    auto_set_en = 0;
    load(9);
    chk("R3 wr_ready full", int'(wr_ready), 0);
    chk("R3 req full", int'(dma_req), 0);
    chk("R3 no commit", int'(pkt_count), 0);
    pulse_cpu();
    chk("R5 cpu commit", int'(pkt_count), 1);
    chk("R3 ready again", int'(wr_ready), 1);
    // R4 auto commit fills second slot
    auto_set_en = 1;
    load(8);
    chk("R4 auto count", int'(pkt_count), 2);
    chk("R6 rdy full", int'(pkt_rdy), 1);
    chk("R6 req low", int'(dma_req), 0);
    chk("R6 wr_ready low", int'(wr_ready), 0);
    pulse_cpu();
    chk("R5 ignored full", int'(pkt_count), 2);
    // R7 success frees slots
    pulse_ok();
    chk("R7 dec", int'(pkt_count), 1);
    chk("R7 rdy clear", int'(pkt_rdy), 0);
    chk("R4 req back", int'(dma_req), 1);
    pulse_ok();
    pulse_ok();
    chk("R7 empty ignore", int'(pkt_count), 0);
    // R5 short and null packets
    load(3);
    pulse_cpu();
    chk("R5 short", int'(pkt_count), 1);
    pulse_cpu();
    chk("R5 null", int'(pkt_count), 2);
    // R9 commit with success
    pulse_ok();
    cpu_set_rdy = 1; tx_ok = 1; nxt(); cpu_set_rdy = 0; tx_ok = 0;
    chk("R9 unchanged", int'(pkt_count), 1);
    // R8 retry tally
    host_mode = 1;
    pulse_fail(); pulse_fail();
    chk("R8 two strikes", int'(tx_err), 0);
    pulse_ok();
    pulse_cpu();
    pulse_fail(); pulse_fail();
    chk("R8 tally reset by ok", int'(tx_err), 0);
    pulse_fail();
    chk("R8 third strike", int'(tx_err), 1);
    chk("R8 req masked", int'(dma_req), 0);
    err_clr = 1; nxt(); err_clr = 0;
    chk("R8 cleared", int'(tx_err), 0);
    chk("R8 req restored", int'(dma_req), 1);
    host_mode = 0;
    pulse_fail(); pulse_fail(); pulse_fail();
    chk("R8 device ignore", int'(tx_err), 0);
    host_mode = 1;
    tx_ok = 1; tx_fail = 1; nxt(); tx_ok = 0; tx_fail = 0;
    chk("R8 ok wins count", int'(pkt_count), 0);
    pulse_fail(); pulse_fail(); pulse_fail();
    chk("R8 empty ignore", int'(tx_err), 0);
    // Random run against the model
    max_pkt_size = 10'd16;
    for (int i = 0; i < 4000; i++) begin
      wr_valid    = ($urandom_range(0, 9) < 7);
      cpu_set_rdy = ($urandom_range(0, 19) == 0);
      tx_ok       = ($urandom_range(0, 9) == 0);
      tx_fail     = ($urandom_range(0, 7) == 0);
      err_clr     = ($urandom_range(0, 29) == 0);
      if ($urandom_range(0, 99) == 0) auto_set_en = ~auto_set_en;
      if ($urandom_range(0, 149) == 0) host_mode = ~host_mode;
      nxt();
    end
    wr_valid = 0; cpu_set_rdy = 0; tx_ok = 0; tx_fail = 0; err_clr = 0;
    nxt();
    finish_run();
  end
endmodule